// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a serial-bus slave that gives a system-management master access to a small file of eight-bit control registers. The block oversamples the bus clock and data lines with a faster system clock. It drives the data line only through an open-drain pull-down enable. Every transfer names a starting register offset and a byte count. A write frame carries the write address, the offset, the count and then the data bytes. A read frame sends the write address and the offset, then a repeated start with the read address. The slave answers the read with a count byte and then register data, beginning at the named offset. The offset advances after each data byte and wraps at the end of the file.

Register 7 holds a fixed identification byte. The low three bits of register 6 mirror three strap inputs. Neither can be overwritten from the bus. The rest of the chip sees every stored byte through a one-cycle write strobe. It can also look at any register through a combinational read port.

Top module: `smb_regslave`

## Requirements
- R1: The slave acknowledges the address bytes D2h (write) and D3h (read). Any other address byte is not acknowledged, and SDA stays released until the next start or stop.
- R2: In a write frame, the slave acknowledges the offset byte, the count byte and each data byte. The low five bits of the offset select the register and the upper three bits are ignored. Each data byte is stored at the current offset.
- R3: A count byte of 00h is not acknowledged, and no register changes for the rest of that frame.
- R4: Data bytes beyond the count are not acknowledged and are not stored.
- R5: A read returns a count byte first, followed by register data starting at the offset. The count byte is the last nonzero count received in a write frame, and it is 08h after reset.
- R6: The register offset advances by one after each data byte and wraps from 31 to 0, for both reads and writes.
- R7: When the master does not acknowledge a read byte and then issues a stop, the slave releases SDA. The next frame then works normally.
- R8: Register 7 always reads 05h, and writes to it are dropped. Bits 2:0 of register 6 always read the strap inputs, with strap_i[2] in bit 2. Writes to those three bits are dropped.
- R9: A start in the middle of a frame restarts address reception. The abandoned frame stores nothing further.
- R10: Each stored byte produces a one-cycle pulse on wr_stb, with its register index and stored value. host_data shows register host_idx at all times.
- R11: The slave asserts its SDA pull-down only while SCL is low.
- R12: After reset, SDA is released and every writable register reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Latched strap values shown in register 6 bits 2:0 |
| host_idx | input | 5 | Register index for the local read port |
| host_data | output | 8 | Contents of register host_idx |
| wr_stb | output | 1 | One-cycle pulse per stored byte |
| wr_idx | output | 5 | Index of the stored byte |
| wr_data | output | 8 | Value stored |

## Verification
The assertions assume a bus master that respects the two-wire protocol. SDA changes only while SCL is low, except to form start and stop conditions. The master never forms a start or stop while the slave is pulling SDA low. Each SCL phase also lasts well beyond the three-cycle synchronizer and edge-detect delay. The bench master holds every SCL quarter phase for ten system clocks. It changes its own SDA only in the middle of a low phase. It issues a stop only after releasing the line on a not-acknowledge or after a slave acknowledge has ended.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] ID_BYTE   = 8'h05,
  parameter logic [7:0] CNT_RESET = 8'd8,
  parameter int         NREG      = 32,
  localparam int        IW        = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    strap_i,
  input  logic [IW-1:0] host_idx,
  output logic [7:0]    host_data,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_OFFS, S_CNT, S_WDAT, S_TX, S_SKIP} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           st, nxt;
  logic [3:0]    bitc;
  logic [7:0]    sh, txb, left, rdcnt;
  logic [IW-1:0] ptr;
  logic          mnack;
  logic [7:0]    regs [NREG];
  logic [7:0]    cur;

  wire scl_s   = scl_sy[1];
  wire sda_s   = sda_sy[1];
  wire start_c = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c  = scl_s & scl_q & ~sda_q & sda_s;
  wire rise    = scl_s & ~scl_q;
  wire fall    = ~scl_s & scl_q;

  function automatic logic [7:0] view(input logic [IW-1:0] i);
    if (i == IW'(7)) return ID_BYTE;
    if (i == IW'(6)) return {regs[6][7:3], strap_i};
    return regs[i];
  endfunction

  assign cur       = view(ptr);
  assign host_data = view(host_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;              sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; nxt <= S_IDLE; bitc <= '0; sh <= '0; txb <= '0;
      left <= '0; rdcnt <= CNT_RESET; ptr <= '0; mnack <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_c) begin
        st <= S_ADDR; bitc <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; bitc <= '0; sda_oe <= 1'b0;
      end else if (st != S_IDLE && st != S_SKIP) begin
        if (rise) begin
          if (bitc < 4'd8) sh <= {sh[6:0], sda_s};
          else             mnack <= sda_s;
          bitc <= bitc + 4'd1;
        end else if (fall && st == S_TX) begin
          if (bitc >= 4'd1 && bitc <= 4'd7) begin
            txb <= {txb[6:0], 1'b0}; sda_oe <= ~txb[6];
          end else if (bitc == 4'd8) begin
            sda_oe <= 1'b0;
          end else if (bitc == 4'd9) begin
            bitc <= '0;
            if (mnack) begin
              st <= S_SKIP; sda_oe <= 1'b0;
            end else begin
              txb <= cur; sda_oe <= ~cur[7]; ptr <= ptr + IW'(1);
            end
          end
        end else if (fall) begin
          if (bitc == 4'd8) begin
            sda_oe <= 1'b0;
            case (st)
              S_ADDR:
                if (sh == {DEV_ADDR, 1'b0})      begin nxt <= S_OFFS; sda_oe <= 1'b1; end
                else if (sh == {DEV_ADDR, 1'b1}) begin nxt <= S_TX;   sda_oe <= 1'b1; end
                else st <= S_SKIP;
              S_OFFS: begin ptr <= sh[IW-1:0]; nxt <= S_CNT; sda_oe <= 1'b1; end
              S_CNT:
                if (sh == 8'd0) st <= S_SKIP;
                else begin left <= sh; rdcnt <= sh; nxt <= S_WDAT; sda_oe <= 1'b1; end
              S_WDAT:
                if (left == 8'd0) st <= S_SKIP;
                else begin
                  if (ptr != IW'(7)) begin
                    regs[ptr] <= (ptr == IW'(6)) ? {sh[7:3], 3'b000} : sh;
                    wr_stb  <= 1'b1;
                    wr_idx  <= ptr;
                    wr_data <= (ptr == IW'(6)) ? {sh[7:3], 3'b000} : sh;
                  end
                  ptr <= ptr + IW'(1); left <= left - 8'd1; nxt <= S_WDAT; sda_oe <= 1'b1;
                end
              default: ;
            endcase
          end else if (bitc == 4'd9) begin
            bitc <= '0; st <= nxt;
            if (nxt == S_TX) begin txb <= rdcnt; sda_oe <= ~rdcnt[7]; end
            else sda_oe <= 1'b0;
          end
        end
      end
    end
  end

  // R1
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE || st == S_SKIP) |-> !sda_oe);

  // R11
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R8
  ro_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_idx != IW'(7)));

  // R10
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

endmodule

// File: tb/smb_regslave_bench.sv
`timescale 1ns/1ps
module smb_regslave_bench;
  localparam int Q = 10;
  localparam logic [23:0] VEC [0:5] = '{
    24'h00A5A5, 24'h1F3C3C, 24'h07FF05, 24'h06FFFD, 24'h237777, 24'h100000 };

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  logic sda_oe, wr_stb;
  logic [2:0] strap = 3'b101;
  logic [4:0] host_idx = '0, wr_idx, last_idx;
  logic [7:0] host_data, wr_data, last_dat;
  int checks = 0, errors = 0, nstb = 0;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_regslave u_smb_regslave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .host_idx(host_idx), .host_data(host_data),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data));

  always @(posedge clk) if (wr_stb) begin nstb++; last_idx <= wr_idx; last_dat <= wr_data; end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic hold(); repeat (Q) @(negedge clk); endtask

  task automatic start();
    sda_m = 1; hold(); scl_m = 1; hold(); sda_m = 0; hold(); scl_m = 0; hold();
  endtask

  task automatic stop();
    sda_m = 0; hold(); scl_m = 1; hold(); sda_m = 1; hold();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(); scl_m = 1; hold(); hold(); scl_m = 0; hold();
    end
    sda_m = 1; hold(); scl_m = 1; hold(); ack = sda_line; hold(); scl_m = 0; hold();
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; hold(); scl_m = 1; hold(); d[i] = sda_line; hold(); scl_m = 0; hold();
    end
    sda_m = nack; hold(); scl_m = 1; hold(); hold(); scl_m = 0; hold(); sda_m = 1;
  endtask

  task automatic peek(input logic [4:0] idx, input logic [7:0] exp, input string req);
    host_idx = idx; #1; chk(req, host_data, exp);
  endtask

  task automatic wr_frame(input logic [7:0] off, input logic [7:0] cnt,
                          input logic [7:0] d0, input string req);
    logic a;
    start();
    wbyte(8'hD2, a); chk({req, " addr ack"}, {7'd0, a}, 8'd0);
    wbyte(off, a);   chk({req, " offset ack"}, {7'd0, a}, 8'd0);
    wbyte(cnt, a);   chk({req, " count ack"}, {7'd0, a}, 8'd0);
    wbyte(d0, a);    chk({req, " data ack"}, {7'd0, a}, 8'd0);
  endtask

  task automatic rd_open(input logic [7:0] off, input logic [7:0] ecnt, input string req);
    logic a; logic [7:0] d;
    start(); wbyte(8'hD2, a); wbyte(off, a);
    start(); wbyte(8'hD3, a); chk({req, " read addr ack"}, {7'd0, a}, 8'd0);
    rbyte(1'b0, d); chk({req, " count byte"}, d, ecnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; $display("FAIL watchdog: got hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic a; logic [7:0] d;
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    // R12
    chk("R12 sda released", {7'd0, sda_oe}, 8'd0);
    peek(5'd0, 8'h00, "R12 reg0");
    peek(5'd31, 8'h00, "R12 reg31");
    // R5 count after reset, R8 id byte
    rd_open(8'h07, 8'h08, "R5");
    rbyte(1'b1, d); stop(); chk("R8 id read", d, 8'h05);

    foreach (VEC[k]) begin
      wr_frame(VEC[k][23:16], 8'h01, VEC[k][15:8], "R2"); stop();
      rd_open(VEC[k][23:16], 8'h01, "R5");
      rbyte(1'b1, d); stop();
      chk("R2 R8 readback", d, VEC[k][7:0]);
      peek(VEC[k][20:16], VEC[k][7:0], "R10 host port");
    end

    // R6 wrap write and read, R10 strobes
    nstb = 0;
    wr_frame(8'd30, 8'd4, 8'h11, "R6");
    wbyte(8'h22, a); wbyte(8'h33, a); wbyte(8'h44, a); stop();
    chk("R10 strobe count", 8'(nstb), 8'd4);
    chk("R10 last idx", {3'd0, last_idx}, 8'd1);
    chk("R10 last data", last_dat, 8'h44);
    rd_open(8'd30, 8'd4, "R6");
    rbyte(1'b0, d); chk("R6 byte30", d, 8'h11);
    rbyte(1'b0, d); chk("R6 byte31", d, 8'h22);
    rbyte(1'b0, d); chk("R6 wrap byte0", d, 8'h33);
    rbyte(1'b1, d); chk("R6 byte1", d, 8'h44);
    stop();

    // R7 early end of read
    rd_open(8'd30, 8'd4, "R7");
    rbyte(1'b0, d); rbyte(1'b1, d); stop(); repeat (4) @(negedge clk);
    chk("R7 released", {7'd0, sda_oe}, 8'd0);
    rd_open(8'd0, 8'd4, "R7");
    rbyte(1'b1, d); stop(); chk("R7 next read", d, 8'h33);

    // R3 zero count
    wr_frame(8'd10, 8'd1, 8'h99, "R3"); stop();
    nstb = 0;
    start(); wbyte(8'hD2, a); wbyte(8'd10, a); wbyte(8'd0, a);
    chk("R3 zero count nack", {7'd0, a}, 8'd1);
    wbyte(8'h55, a); stop();
    peek(5'd10, 8'h99, "R3 reg10 kept");
    chk("R3 no strobe", 8'(nstb), 8'd0);

    // R4 over count
    wr_frame(8'd12, 8'd1, 8'h5A, "R4");
    wbyte(8'h6B, a); chk("R4 extra nack", {7'd0, a}, 8'd1); stop();
    peek(5'd12, 8'h5A, "R4 reg12");
    peek(5'd13, 8'h00, "R4 reg13 kept");

    // R1 foreign address
    start(); wbyte(8'hA4, a); chk("R1 foreign nack", {7'd0, a}, 8'd1);
    wbyte(8'h00, a); chk("R1 stays released", {7'd0, a}, 8'd1); stop();

    // R9 restart mid frame
    start(); wbyte(8'hD2, a); wbyte(8'd5, a);
    wr_frame(8'd14, 8'd1, 8'hC3, "R9"); stop();
    peek(5'd14, 8'hC3, "R9 reg14");
    peek(5'd5, 8'h00, "R9 reg5 kept");

    // R8 strap follow
    strap = 3'b010; #1;
    peek(5'd6, 8'hFA, "R8 strap live");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule